// File: doc/BRIEF.md
# Restoring Array Divider

This block divides an unsigned N-bit dividend by an unsigned N-bit divisor in pure combinational logic and yields an N-bit quotient and, optionally, an N-bit remainder. It holds no state and needs no clock. Outputs follow the inputs after the settling delay of the array.

The divider is a fully unrolled grid of N subtractor rows, one row for each quotient bit. The first row produces the most significant quotient bit. Each row shifts the previous partial remainder left by one place and puts the next lower dividend bit in at the bottom. It then tries to subtract the divisor through a chain of full-subtractor cells whose lowest borrow-in is held at 0. The row's final borrow, inverted, is its quotient bit. A per-bit 2:1 multiplexer passes the difference down when there was no borrow. When there was a borrow, it passes the shifted value down unchanged, which is the restore.

The last row restores only when the remainder output is enabled. Otherwise only its borrow is used. A divisor of zero gives undefined outputs and is outside the block's contract.

Top module: `restoring_divider`

## Requirements
- R1: For any divisor other than zero, `quotient` equals the integer floor of `dividend / divisor`.
- R2: With the remainder enabled (REM_EN=1), `remainder` equals `dividend` modulo `divisor` for any divisor other than zero.
- R3: For any divisor other than zero, `remainder` is strictly less than `divisor`, and `quotient * divisor + remainder` equals `dividend`.
- R4: A divisor of 1 gives `quotient` equal to `dividend` and `remainder` equal to 0.
- R5: A dividend smaller than the divisor gives `quotient` 0 and `remainder` equal to `dividend`.
- R6: A dividend equal to a non-zero divisor gives `quotient` 1 and `remainder` 0.
- R7: The most significant quotient bit, `quotient[N-1]`, is produced by the first row. It is 1 only when the divisor is 1 and `dividend[N-1]` is 1.
- R8: The block is combinational. Both outputs follow a change of the inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | N | Unsigned dividend |
| divisor | input | N | Unsigned divisor; zero is outside the contract |
| quotient | output | N | Unsigned quotient, one bit per subtractor row |
| remainder | output | N | Unsigned remainder; constant 0 when REM_EN=0 |

## Verification
Every dividend and divisor pair of a 4-bit instance is applied. This covers every mix of borrow and no-borrow across the rows, so a wrong restore choice in any row shows up.

On the 8-bit instance, a fixed table of pairs is applied first. The table separates exact division, a remainder of one less than the divisor, a dividend below the divisor, and the largest operands. Directed cases for a divisor of one, equal operands and a set top dividend bit then isolate the first row and the shift-in path. Random 8-bit pairs follow.

Inputs change between clock edges, and the outputs are read without any edge in between. This checks that nothing in the array waits for a clock.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    // Result of one full-subtractor bit: difference and borrow-out
    typedef struct packed {
        logic diff;
        logic bout;
    } sub_bit_t;

endpackage

// File: rtl/rdiv_sub_cell.sv
module rdiv_sub_cell
    import rdiv_pkg::*;
(
    input  logic     x,
    input  logic     y,
    input  logic     bin,
    output sub_bit_t res
);
    sub_bit_t res_d;

    always_comb begin
        res_d.diff = x ^ y ^ bin;
        res_d.bout = (~x & y) | (~(x ^ y) & bin);
    end

    assign res = res_d;
endmodule

// File: rtl/rdiv_row.sv
// One trial-subtraction row. part holds the shifted partial remainder
// (N+1 bits); the top bit has no divisor bit, so it only cancels the borrow.
module rdiv_row
    import rdiv_pkg::*;
#(
    parameter int N       = 8,
    parameter bit RESTORE = 1'b1
) (
    input  logic [N:0]   part,
    input  logic [N-1:0] dvs,
    output logic [N-1:0] nxt,
    output logic         qbit
);
    logic [N:0]   chain;
    logic [N-1:0] diff_w;
    logic         row_borrow;

    assign chain[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_cell
        sub_bit_t cell_res;
        rdiv_sub_cell u_cell (
            .x   (part[k]),
            .y   (dvs[k]),
            .bin (chain[k]),
            .res (cell_res)
        );
        assign diff_w[k]  = cell_res.diff;
        assign chain[k+1] = cell_res.bout;
    end

    // The top shifted bit has weight 2^N, which is above any divisor
    assign row_borrow = chain[N] & ~part[N];
    assign qbit       = ~row_borrow;

    if (RESTORE) begin : g_restore
        for (genvar k = 0; k < N; k++) begin : g_mux
            assign nxt[k] = row_borrow ? part[k] : diff_w[k];
        end
    end else begin : g_plain
        assign nxt = diff_w;
    end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import rdiv_pkg::*;
#(
    parameter int N      = 8,
    parameter bit REM_EN = 1'b1
) (
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder
);
    localparam int ROWS = N;

    logic [N-1:0] row_rem [ROWS];
    logic [N:0]   row_in  [ROWS];
    logic [N-1:0] q_w;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        localparam bit LAST = (i == ROWS - 1);

        if (i == 0) begin : g_first
            assign row_in[i] = {{N{1'b0}}, dividend[N-1]};
        end else begin : g_next
            assign row_in[i] = {row_rem[i-1], dividend[N-1-i]};
        end

        rdiv_row #(
            .N       (N),
            .RESTORE (LAST ? REM_EN : 1'b1)
        ) u_row (
            .part (row_in[i]),
            .dvs  (divisor),
            .nxt  (row_rem[i]),
            .qbit (q_w[N-1-i])
        );
    end

    assign quotient = q_w;

    if (REM_EN) begin : g_rem
        assign remainder = row_rem[ROWS-1];
    end else begin : g_norem
        assign remainder = '0;
    end
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
    parameter int N      = 8,
    parameter bit REM_EN = 1'b1
) (
    input logic [N-1:0] dividend,
    input logic [N-1:0] divisor,
    input logic [N-1:0] quotient,
    input logic [N-1:0] remainder
);
    logic [2*N:0] recon;

    always_comb begin
        recon = {{(N+1){1'b0}}, quotient} * {{(N+1){1'b0}}, divisor}
              + {{(N+1){1'b0}}, remainder};
        if (divisor != '0) begin
            // R1: the quotient never exceeds the dividend
            a_r1_q_bound: assert (quotient <= dividend);
            if (REM_EN) begin
                a_r3_rem_below: assert (remainder < divisor);
                a_r3_recon: assert (recon == {{(N+1){1'b0}}, dividend});
            end
            if (divisor == {{(N-1){1'b0}}, 1'b1}) begin
                a_r4_unit: assert (quotient == dividend);
            end
            if (dividend < divisor) begin
                a_r5_small: assert (quotient == '0);
            end
            a_r7_top_bit: assert (!quotient[N-1] ||
                (divisor == {{(N-1){1'b0}}, 1'b1} && dividend[N-1]));
        end
    end
endmodule

bind restoring_divider restoring_divider_chk #(.N(N), .REM_EN(REM_EN)) u_chk (
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/restoring_divider_test.sv
module restoring_divider_test;
    localparam int W  = 8;
    localparam int WS = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0]  a, b, q, r;
    logic [WS-1:0] as, bs, qs, rs;
    int checks = 0;
    int errors = 0;

    restoring_divider #(.N(W), .REM_EN(1'b1)) uut (
        .dividend(a), .divisor(b), .quotient(q), .remainder(r));
    restoring_divider #(.N(WS), .REM_EN(1'b1)) uut4 (
        .dividend(as), .divisor(bs), .quotient(qs), .remainder(rs));

    // {dividend, divisor, quotient, remainder}
    localparam logic [31:0] VEC [10] = '{
        {8'd200, 8'd7,   8'd28,  8'd4},
        {8'd255, 8'd16,  8'd15,  8'd15},
        {8'd100, 8'd10,  8'd10,  8'd0},
        {8'd13,  8'd200, 8'd0,   8'd13},
        {8'd255, 8'd255, 8'd1,   8'd0},
        {8'd128, 8'd1,   8'd128, 8'd0},
        {8'd255, 8'd2,   8'd127, 8'd1},
        {8'd0,   8'd9,   8'd0,   8'd0},
        {8'd99,  8'd98,  8'd1,   8'd1},
        {8'd250, 8'd3,   8'd83,  8'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply8(input logic [W-1:0] da, input logic [W-1:0] db);
        @(posedge clk);
        #2;
        a = da;
        b = db;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        a = '0; b = 8'd1; as = '0; bs = 4'd1;
        @(negedge clk);
        chk("R4 initial q", int'(q), 0);
        chk("R4 initial r", int'(r), 0);

        // table walk: R1 R2
        foreach (VEC[i]) begin
            apply8(VEC[i][31:24], VEC[i][23:16]);
            chk("R1 table q", int'(q), int'(VEC[i][15:8]));
            chk("R2 table r", int'(r), int'(VEC[i][7:0]));
        end

        // exhaustive 4-bit: R1 R2 R3
        for (int x = 0; x < 16; x++) begin
            for (int y = 1; y < 16; y++) begin
                @(posedge clk);
                #2;
                as = WS'(x);
                bs = WS'(y);
                @(negedge clk);
                chk("R1 4b q", int'(qs), x / y);
                chk("R2 4b r", int'(rs), x % y);
                chk("R3 4b r<b", int'(rs < bs), 1);
            end
        end

        // R4 divisor one
        apply8(8'd173, 8'd1);
        chk("R4 q", int'(q), 173);
        chk("R4 r", int'(r), 0);
        // R5 dividend below divisor
        apply8(8'd254, 8'd255);
        chk("R5 q", int'(q), 0);
        chk("R5 r", int'(r), 254);
        // R6 equal operands
        apply8(8'd77, 8'd77);
        chk("R6 q", int'(q), 1);
        chk("R6 r", int'(r), 0);
        // R7 top quotient bit
        apply8(8'd200, 8'd1);
        chk("R7 top set", int'(q[W-1]), 1);
        apply8(8'd200, 8'd2);
        chk("R7 top clear", int'(q[W-1]), 0);
        apply8(8'd127, 8'd1);
        chk("R7 top clear small", int'(q[W-1]), 0);

        // R8 outputs follow inputs with no clock edge in between
        @(negedge clk);
        a = 8'd90; b = 8'd4;
        #3;
        chk("R8 q", int'(q), 22);
        chk("R8 r", int'(r), 2);
        a = 8'd91; b = 8'd13;
        #3;
        chk("R8 q2", int'(q), 7);
        chk("R8 r2", int'(r), 0);

        // random 8-bit: R1 R2 R3
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (rb == '0) rb = 8'd3;
            apply8(ra, rb);
            chk("R1 rnd q", int'(q), int'(ra) / int'(rb));
            chk("R2 rnd r", int'(r), int'(ra) % int'(rb));
            chk("R3 rnd recon", int'(q) * int'(rb) + int'(r), int'(ra));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule